// File: doc/BRIEF.md
# Dual-Section Bidirectional Bus Transceiver with Parity

This block holds a set of independent transceiver sections. Each section passes one data word between an A side and a B side. A per-section direction control sets which way the word travels. Tri-state pins are split into a data-out vector and a drive-enable signal for each side, so the block stays synthesizable. The pad logic at chip level combines them.

Each section also has a parity pin whose role follows the direction.

- When a section transmits (A to B), it computes a parity bit from the A word and drives it on the parity pin.
- When a section receives (B to A), the parity pin is an input. The section checks it together with the B word and pulls an active-low error flag when the parity sense is wrong.

The parity sense (odd or even) is chosen per section. An active-low output enable turns off every driver of its section.

The block is purely combinational. No handshake or clock applies to the data path.

Top module: `bidir_parity_xcvr`

## Requirements
- R1: Each section (default two, each 8 bits wide) behaves only from its own inputs. Changing one section's inputs never alters another section's outputs.
- R2: With `xfer_dir` high (transmit) and `oe_n` low, `b_drv` is 1, `b_out` equals `a_in`, and `a_drv` is 0.
- R3: With `xfer_dir` low (receive) and `oe_n` low, `a_drv` is 1, `a_out` equals `b_in`, and `b_drv` is 0.
- R4: With `oe_n` high, `a_drv`, `b_drv` and `par_drv` of that section are all 0 and `err_n` is 1, whatever the other inputs are.
- R5: In transmit with `oe_n` low, `par_out` makes the count of ones across the A word plus `par_out` odd when `odd_sel` is 1 and even when it is 0. For example, even sense with five A bits set gives `par_out` = 1.
- R6: `par_drv` is 1 exactly when the section is transmitting with `oe_n` low.
- R7: In receive with `oe_n` low, `err_n` is 0 exactly when the count of ones across the B word plus `par_in` does not match the selected sense. For example, odd sense, `par_in` = 1 and three B bits set gives `err_n` = 0.
- R8: `err_n` is 1 whenever the section is transmitting.
- R9: A data output whose drive enable is 0 reads all zeros. This applies to `a_out` and `b_out`, and to `par_out` when `par_drv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | NUM_SECT*WIDTH | A-side word sensed at the pins, section s in bits [s*WIDTH +: WIDTH] |
| a_out | output | NUM_SECT*WIDTH | Word driven onto the A side |
| a_drv | output | NUM_SECT | A-side drive enable per section |
| b_in | input | NUM_SECT*WIDTH | B-side word sensed at the pins |
| b_out | output | NUM_SECT*WIDTH | Word driven onto the B side |
| b_drv | output | NUM_SECT | B-side drive enable per section |
| xfer_dir | input | NUM_SECT | 1 = transmit A to B, 0 = receive B to A |
| oe_n | input | NUM_SECT | Active-low output enable |
| odd_sel | input | NUM_SECT | 1 = odd parity, 0 = even parity |
| par_in | input | NUM_SECT | Parity pin as sensed (used in receive) |
| par_out | output | NUM_SECT | Generated parity bit (used in transmit) |
| par_drv | output | NUM_SECT | Parity pin drive enable |
| err_n | output | NUM_SECT | Active-low parity error flag |

## Verification
The block has no registers, so every output is due in the same cycle as the stimulus that causes it. The bench applies each vector on a rising clock edge and samples all outputs at the next falling edge. By then the combinational paths have settled, and no result depends on the order of processes at an edge. Section 0 is swept exhaustively over all data, sense, direction, parity-input and enable values while section 1 receives random values. The roles are then swapped, so any leakage between sections shows up in the sampled outputs.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    XFER_RECEIVE  = 1'b0,
    XFER_TRANSMIT = 1'b1
  } xfer_dir_e;

  typedef struct packed {
    logic a_en;
    logic b_en;
    logic p_en;
    logic chk_en;
  } drive_plan_t;
endpackage

// File: rtl/xcvr_parity_tree.sv
module xcvr_parity_tree #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] word,
  output logic             odd_ones
);
  localparam int STAGES = WIDTH + 1;
  logic [STAGES-1:0] chain;

  assign chain[0] = 1'b0;
  for (genvar k = 0; k < WIDTH; k++) begin : g_chain
    assign chain[k+1] = chain[k] ^ word[k];
  end
  assign odd_ones = chain[STAGES-1];
endmodule

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
  import xcvr_pkg::*;
(
  input  logic        dir,
  input  logic        oe_n,
  output drive_plan_t plan
);
  xfer_dir_e mode;
  logic      live;

  always_comb begin
    mode        = xfer_dir_e'(dir);
    live        = ~oe_n;
    plan.a_en   = live && (mode == XFER_RECEIVE);
    plan.b_en   = live && (mode == XFER_TRANSMIT);
    plan.p_en   = live && (mode == XFER_TRANSMIT);
    plan.chk_en = live && (mode == XFER_RECEIVE);
  end
endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             dir,
  input  logic             oe_n,
  input  logic             odd_sel,
  input  logic             par_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drv,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drv,
  output logic             par_out,
  output logic             par_drv,
  output logic             err_n
);
  drive_plan_t plan;
  logic        a_odd;
  logic        b_odd;
  logic        rx_total_odd;

  xcvr_dir_ctrl i_ctrl (
    .dir  (dir),
    .oe_n (oe_n),
    .plan (plan)
  );

  xcvr_parity_tree #(.WIDTH(WIDTH)) i_gen (
    .word     (a_in),
    .odd_ones (a_odd)
  );

  xcvr_parity_tree #(.WIDTH(WIDTH)) i_chk (
    .word     (b_in),
    .odd_ones (b_odd)
  );

  always_comb begin
    rx_total_odd = b_odd ^ par_in;
    a_drv   = plan.a_en;
    b_drv   = plan.b_en;
    par_drv = plan.p_en;
    a_out   = plan.a_en ? b_in : '0;
    b_out   = plan.b_en ? a_in : '0;
    // The generated bit makes the total count of ones odd when odd_sel is set.
    par_out = plan.p_en ? (a_odd ^ odd_sel) : 1'b0;
    err_n   = ~(plan.chk_en && (rx_total_odd != odd_sel));
  end
endmodule

// File: rtl/bidir_parity_xcvr.sv
module bidir_parity_xcvr #(
  parameter int NUM_SECT = 2,
  parameter int WIDTH    = 8
) (
  input  logic [NUM_SECT*WIDTH-1:0] a_in,
  output logic [NUM_SECT*WIDTH-1:0] a_out,
  output logic [NUM_SECT-1:0]       a_drv,
  input  logic [NUM_SECT*WIDTH-1:0] b_in,
  output logic [NUM_SECT*WIDTH-1:0] b_out,
  output logic [NUM_SECT-1:0]       b_drv,
  input  logic [NUM_SECT-1:0]       xfer_dir,
  input  logic [NUM_SECT-1:0]       oe_n,
  input  logic [NUM_SECT-1:0]       odd_sel,
  input  logic [NUM_SECT-1:0]       par_in,
  output logic [NUM_SECT-1:0]       par_out,
  output logic [NUM_SECT-1:0]       par_drv,
  output logic [NUM_SECT-1:0]       err_n
);
  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    xcvr_section #(.WIDTH(WIDTH)) i_sect (
      .a_in    (a_in[s*WIDTH +: WIDTH]),
      .b_in    (b_in[s*WIDTH +: WIDTH]),
      .dir     (xfer_dir[s]),
      .oe_n    (oe_n[s]),
      .odd_sel (odd_sel[s]),
      .par_in  (par_in[s]),
      .a_out   (a_out[s*WIDTH +: WIDTH]),
      .a_drv   (a_drv[s]),
      .b_out   (b_out[s*WIDTH +: WIDTH]),
      .b_drv   (b_drv[s]),
      .par_out (par_out[s]),
      .par_drv (par_drv[s]),
      .err_n   (err_n[s])
    );
  end
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int NUM_SECT = 2,
  parameter int WIDTH    = 8
) (
  input logic [NUM_SECT*WIDTH-1:0] a_out,
  input logic [NUM_SECT-1:0]       a_drv,
  input logic [NUM_SECT*WIDTH-1:0] b_out,
  input logic [NUM_SECT-1:0]       b_drv,
  input logic [NUM_SECT-1:0]       oe_n,
  input logic [NUM_SECT-1:0]       odd_sel,
  input logic [NUM_SECT-1:0]       par_in,
  input logic [NUM_SECT-1:0]       par_out,
  input logic [NUM_SECT-1:0]       par_drv,
  input logic [NUM_SECT-1:0]       err_n
);
  always_comb begin
    for (int s = 0; s < NUM_SECT; s++) begin
      assert_one_side_R2: assert (!(a_drv[s] && b_drv[s]))
        else $error("R2/R3: both sides driven in section %0d", s);
      assert_quiet_R4: assert (!oe_n[s] || (!a_drv[s] && !b_drv[s] && !par_drv[s] && err_n[s]))
        else $error("R4: section %0d active while disabled", s);
      assert_pin_role_R6: assert (par_drv[s] == b_drv[s])
        else $error("R6: parity drive mismatch in section %0d", s);
      assert_gen_sense_R5: assert (!par_drv[s] || ((^b_out[s*WIDTH +: WIDTH]) ^ par_out[s]) == odd_sel[s])
        else $error("R5: generated parity wrong in section %0d", s);
      assert_rx_check_R7: assert (!a_drv[s] || (err_n[s] == (((^a_out[s*WIDTH +: WIDTH]) ^ par_in[s]) == odd_sel[s])))
        else $error("R7: error flag wrong in section %0d", s);
      assert_tx_clean_R8: assert (!b_drv[s] || err_n[s])
        else $error("R8: error flagged while transmitting in section %0d", s);
      assert_idle_zero_R9: assert (par_drv[s] || !par_out[s])
        else $error("R9: parity output not zero while undriven in section %0d", s);
    end
  end
endmodule

bind bidir_parity_xcvr xcvr_checker #(.NUM_SECT(NUM_SECT), .WIDTH(WIDTH)) i_xcvr_checker (
  .a_out   (a_out),
  .a_drv   (a_drv),
  .b_out   (b_out),
  .b_drv   (b_drv),
  .oe_n    (oe_n),
  .odd_sel (odd_sel),
  .par_in  (par_in),
  .par_out (par_out),
  .par_drv (par_drv),
  .err_n   (err_n)
);

// File: tb/test_bidir_parity_xcvr.sv
`timescale 1ns/1ps
module test_bidir_parity_xcvr;
  localparam int NS = 2;
  localparam int W  = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [NS*W-1:0] a_in, a_out, b_in, b_out;
  logic [NS-1:0]   a_drv, b_drv, xfer_dir, oe_n, odd_sel, par_in, par_out, par_drv, err_n;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  bidir_parity_xcvr #(.NUM_SECT(NS), .WIDTH(W)) i_bidir_parity_xcvr (
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
    .xfer_dir(xfer_dir), .oe_n(oe_n), .odd_sel(odd_sel), .par_in(par_in),
    .par_out(par_out), .par_drv(par_drv), .err_n(err_n)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic ones_odd(input logic [W-1:0] v);
    int c = 0;
    for (int k = 0; k < W; k++) c += int'(v[k]);
    return (c % 2) == 1;
  endfunction

  // Compare section s against the requirements-based model.
  task automatic check_sect(input int s);
    logic [W-1:0] ai, bi;
    logic tx, rx, on, e_par, e_err;
    ai = a_in[s*W +: W];
    bi = b_in[s*W +: W];
    on = !oe_n[s];
    tx = on && xfer_dir[s];
    rx = on && !xfer_dir[s];
    e_par = tx ? (ones_odd(ai) ? !odd_sel[s] : odd_sel[s]) : 1'b0;
    e_err = rx ? ((ones_odd(bi) ^ par_in[s]) == odd_sel[s]) : 1'b1;
    check($sformatf("R3/R9 a_out s%0d", s), a_out[s*W +: W], rx ? bi : '0);
    check($sformatf("R2/R9 b_out s%0d", s), b_out[s*W +: W], tx ? ai : '0);
    check($sformatf("R3/R4 a_drv s%0d", s), W'(a_drv[s]), W'(rx));
    check($sformatf("R2/R4 b_drv s%0d", s), W'(b_drv[s]), W'(tx));
    check($sformatf("R5 par_out s%0d", s), W'(par_out[s]), W'(e_par));
    check($sformatf("R6 par_drv s%0d", s), W'(par_drv[s]), W'(tx));
    check($sformatf("R7/R8 err_n s%0d", s), W'(err_n[s]), W'(e_err));
  endtask

  task automatic apply_and_check();
    @(negedge clk);
    for (int s = 0; s < NS; s++) check_sect(s);
    @(posedge clk);
  endtask

  initial begin
    process::self().srandom(32'd20240611);
    a_in = '0; b_in = '0; xfer_dir = '0; oe_n = '1; odd_sel = '0; par_in = '0;
    @(posedge clk);
    // Initial state: all sections disabled (R4).
    apply_and_check();

    // Directed R5: even sense, five A bits set -> parity 1.
    oe_n = '0; xfer_dir = '1; odd_sel = '0; a_in = {W'(8'h00), W'(8'h1F)};
    @(negedge clk);
    check("R5 five ones even", W'(par_out[0]), W'(1'b1));
    @(posedge clk);

    // Directed R7: odd sense, par_in 1, three B bits set -> error.
    xfer_dir = '0; odd_sel = '1; par_in = '1; b_in = {W'(8'h00), W'(8'h07)};
    @(negedge clk);
    check("R7 three ones odd", W'(err_n[0]), W'(1'b0));
    @(posedge clk);

    // Exhaustive sweep on one section, random traffic on the other (R1).
    for (int tgt = 0; tgt < NS; tgt++) begin
      for (int v = 0; v < 256; v++) begin
        for (int m = 0; m < 16; m++) begin
          for (int s = 0; s < NS; s++) begin
            if (s == tgt) begin
              a_in[s*W +: W] = W'(v);
              b_in[s*W +: W] = W'(v);
              xfer_dir[s] = m[0]; oe_n[s] = m[1]; odd_sel[s] = m[2]; par_in[s] = m[3];
            end else begin
              a_in[s*W +: W] = W'($urandom);
              b_in[s*W +: W] = W'($urandom);
              {xfer_dir[s], oe_n[s], odd_sel[s], par_in[s]} = 4'($urandom);
            end
          end
          apply_and_check();
        end
      end
    end

    // R1: hold section 0, vary section 1, section 0 outputs must not move.
    oe_n = '0; xfer_dir = 2'b01; odd_sel = 2'b00; a_in[W-1:0] = 8'hA5; b_in[W-1:0] = 8'h3C;
    @(negedge clk);
    begin
      logic [W-1:0] ref_b;
      logic ref_p;
      ref_b = b_out[W-1:0];
      ref_p = par_out[0];
      for (int k = 0; k < 20; k++) begin
        @(posedge clk);
        a_in[2*W-1:W] = W'($urandom); b_in[2*W-1:W] = W'($urandom);
        {xfer_dir[1], oe_n[1], odd_sel[1], par_in[1]} = 4'($urandom);
        @(negedge clk);
        check("R1 b_out s0 isolated", b_out[W-1:0], ref_b);
        check("R1 par_out s0 isolated", W'(par_out[0]), W'(ref_p));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule